// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is a bank of control and status words reached through a plain 32-bit register bus: a byte address inside a 4 KB window, a write strobe, write data and combinational read data. Board software reads a fixed identity word, drives an LED word, keeps scratch flags and non-volatile flags, reads a free-running timebase and asks for a system reset.

Software cannot reset the system by a stray write. The reset-control word only takes a write after a 16-bit unlock key has been written to the key register. The bit that triggers a reset depends on the board variant, which is chosen by a parameter. On one variant the reset-control word is absent altogether. An accepted trigger gives a single-cycle request pulse that is registered on the bus clock. The timebase counts a clock-enable that is divided down outside the block, normally at 24 MHz.

Flags come in two kinds, and each kind has one word that sets bits and another word that clears them. The ordinary flags clear on a warm reset. The non-volatile flags clear only on the power-on reset.

Top module: `sysctl_regbank`

## Requirements
- R1: Word 0x00 reads the parameter `ID_VALUE`, whose bits [27:16] hold the board-type code. Writes to 0x00 have no effect.
- R2: Word 0x08 is a 32-bit read/write LED register. It is cleared by warm reset.
- R3: Writing 0x20 with data exactly 0x0000A05F stores 0xA05F. Any other data stores {1'b0, data[14:0]}. 0x20 reads back the stored 16 bits zero-extended, so bit 15 reads 1 only while the key is present.
- R4: Word 0x30 reads the flags. A write to 0x30 ORs the data into the flags. A write to 0x34 clears every flag bit that is 1 in the data. The flags clear on warm reset.
- R5: Word 0x38 reads the non-volatile flags. A write to 0x38 sets bits and a write to 0x3C clears them. A warm reset leaves them unchanged and only `por_n` clears them.
- R6: In variants A and B (`VARIANT` 0 and 1), word 0x40 stores the write data only while the key register holds 0xA05F, and it reads back the stored level. While the key is absent, a write to 0x40 leaves the level and `sys_reset_req` unchanged.
- R7: An accepted 0x40 write with the trigger bit set drives `sys_reset_req` high for exactly the one cycle after the write edge. The trigger bit is bit 8 in variant A and bit 2 in variant B. The other bits never trigger.
- R8: In variant C (`VARIANT` 2), word 0x40 reads zero, ignores writes and never raises `sys_reset_req`.
- R9: Word 0x5C reads a counter that adds one on each clock edge where `tick_en` is high and holds otherwise. It clears on warm reset.
- R10: Address bits [1:0] are ignored. Every other offset, including 0x34, 0x3C and any address at 0x100 or above, reads zero. Writes there change no register.
- R11: After reset every readable register except the identity word reads zero, and `sys_reset_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | Warm reset, synchronous, active low; spares non-volatile flags |
| tick_en | input | 1 | Timebase enable, one pulse per 24 MHz period |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds two copies on the same bus. `dut` uses variant A, so bit 8 triggers a reset, and a value with bit 2 set proves that bit 2 does not. The second copy uses variant C, where the same accepted writes must read zero and never pulse. The key sequence checks the locked case, the unlocked case, a near-miss value and relocking on both copies. Warm and power-on resets are applied in turn to separate the two flag kinds.

// File: rtl/sysctl_pkg.sv
// Package: shared constants, board variant type and word-index map for the
// system control register bank. Word index = byte offset >> 2.
package sysctl_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

    typedef enum logic [1:0] {
        VAR_A = 2'd0,   // trigger bit 8
        VAR_B = 2'd1,   // trigger bit 2
        VAR_C = 2'd2    // no reset-control register
    } board_var_e;

    localparam logic [9:0] W_IDENT  = 10'd0;   // 0x00
    localparam logic [9:0] W_LEDS   = 10'd2;   // 0x08
    localparam logic [9:0] W_KEY    = 10'd8;   // 0x20
    localparam logic [9:0] W_FSET   = 10'd12;  // 0x30
    localparam logic [9:0] W_FCLR   = 10'd13;  // 0x34
    localparam logic [9:0] W_NVSET  = 10'd14;  // 0x38
    localparam logic [9:0] W_NVCLR  = 10'd15;  // 0x3C
    localparam logic [9:0] W_RSTCTL = 10'd16;  // 0x40
    localparam logic [9:0] W_TICK   = 10'd23;  // 0x5C

    // Position of the reset trigger bit for a variant.
    function automatic int trig_bit(board_var_e v);
        case (v)
            VAR_A:   return 8;
            VAR_B:   return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_lockkey.sv
// Unlock-key register. Stores the key only on an exact match; any other
// write keeps the low 15 bits, so bit 15 marks the unlocked state.
// Assumes one write strobe per cycle, already address-decoded.
module sysctl_lockkey #(
    parameter int          DW  = 32,
    parameter logic [15:0] KEY = 16'hA05F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [15:0]   key_q,
    output logic          unlocked
);

    localparam logic [DW-1:0] KEY_EXT = DW'(KEY);

    // Key storage: exact key or key with bit 15 forced low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (we)
            key_q <= (wdata == KEY_EXT) ? KEY : {1'b0, wdata[14:0]};
    end

    // Unlock flag seen by the reset-control register.
    assign unlocked = (key_q == KEY);

    // R3: bit 15 never reads high without the full key stored.
    p_key_bit15_r3: assert property (@(posedge clk) disable iff (!rst_n)
        key_q[15] |-> unlocked);

    // R3: a non-key write always leaves bit 15 low.
    p_key_near_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata != KEY_EXT) |=> !key_q[15]);

endmodule

// File: rtl/sysctl_flagbank.sv
// Set/clear flag word. One strobe ORs data in, the other clears bits set in
// data. The reset input decides whether the word is warm or non-volatile.
// Assumes set and clear strobes are never both high.
module sysctl_flagbank #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] flags_q
);

    // Flag update: set has OR semantics, clear has AND-NOT semantics.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (set_we)
            flags_q <= flags_q | wdata;
        else if (clr_we)
            flags_q <= flags_q & ~wdata;
    end

    // R4/R5: every bit named in a set write reads high afterwards.
    p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((flags_q & $past(wdata)) == $past(wdata)));

    // R4/R5: every bit named in a clear write reads low afterwards.
    p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((flags_q & $past(wdata)) == '0));

    // R4/R5: without a strobe the word holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(flags_q));

endmodule

// File: rtl/sysctl_rstctl.sv
// Key-gated reset-control register and reset request pulse. The variant
// parameter picks the trigger bit or removes the register entirely.
// Assumes the unlock flag is registered state from the key register.
module sysctl_rstctl
    import sysctl_pkg::*;
#(
    parameter int         DW      = 32,
    parameter board_var_e VARIANT = VAR_A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          unlocked,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] level_q,
    output logic          req
);

    localparam bit HAS_CTL = (VARIANT != VAR_C);
    localparam int TRIG    = trig_bit(VARIANT);

    generate
        if (HAS_CTL) begin : g_ctl
            logic accept;
            assign accept = we && unlocked;

            // Level register: written only while unlocked.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    level_q <= '0;
                else if (accept)
                    level_q <= wdata;
            end

            // Request pulse: one cycle after an accepted trigger write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    req <= 1'b0;
                else
                    req <= accept && wdata[TRIG] && !req;
            end

            // R7: the request never lasts two cycles.
            p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
                req |=> !req);

            // R7: a request always follows an unlocked trigger write.
            p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
                req |-> $past(we && unlocked && wdata[TRIG]));

            // R6: a locked write leaves the level untouched.
            p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (we && !unlocked) |=> $stable(level_q));
        end else begin : g_none
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst_n, we, unlocked, wdata};
            assign level_q    = '0;
            assign req        = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sysctl_tick.sv
// Timebase counter. Adds one per clock while the external divided enable
// is high; wraps at its width.
module sysctl_tick #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic [CW-1:0] count
);

    // Counter advance on the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick_en)
            count <= count + 1'b1;
    end

    // R9: an enabled edge adds exactly one.
    p_tick_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (count == $past(count) + 1'b1));

    // R9: without the enable the count holds.
    p_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

endmodule

// File: rtl/sysctl_regbank.sv
// System control register bank top. Decodes the word address, routes write
// strobes to the sub-blocks, holds the LED word and muxes read data.
// Assumes single-cycle bus accesses; reads are combinational.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter board_var_e    VARIANT  = VAR_A,
    parameter logic [31:0]   ID_VALUE = 32'h0A5C_0001,
    parameter int            TICK_W   = 32
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [11:0] addr,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        sys_reset_req
);

    localparam int DW     = 32;
    localparam int WORD_W = 10;

    logic [WORD_W-1:0] widx;
    logic              warm_n;
    logic              unused_lo;
    logic [DW-1:0]     led_q;
    logic [15:0]       key_q;
    logic              unlocked;
    logic [DW-1:0]     flags_q;
    logic [DW-1:0]     nvflags_q;
    logic [DW-1:0]     level_q;
    logic [TICK_W-1:0] tick_q;

    assign widx      = addr[11:2];
    assign unused_lo = ^addr[1:0];
    assign warm_n    = rst_n & por_n;

    // LED word, plain read/write.
    always_ff @(posedge clk) begin
        if (!warm_n)
            led_q <= '0;
        else if (wr_en && widx == W_LEDS)
            led_q <= wdata;
    end

    sysctl_lockkey #(.DW(DW), .KEY(UNLOCK_KEY)) u_key (
        .clk      (clk),
        .rst_n    (warm_n),
        .we       (wr_en && widx == W_KEY),
        .wdata    (wdata),
        .key_q    (key_q),
        .unlocked (unlocked)
    );

    sysctl_flagbank #(.DW(DW)) u_flags (
        .clk     (clk),
        .rst_n   (warm_n),
        .set_we  (wr_en && widx == W_FSET),
        .clr_we  (wr_en && widx == W_FCLR),
        .wdata   (wdata),
        .flags_q (flags_q)
    );

    sysctl_flagbank #(.DW(DW)) u_nvflags (
        .clk     (clk),
        .rst_n   (por_n),
        .set_we  (wr_en && widx == W_NVSET),
        .clr_we  (wr_en && widx == W_NVCLR),
        .wdata   (wdata),
        .flags_q (nvflags_q)
    );

    sysctl_rstctl #(.DW(DW), .VARIANT(VARIANT)) u_rstctl (
        .clk      (clk),
        .rst_n    (warm_n),
        .we       (wr_en && widx == W_RSTCTL),
        .unlocked (unlocked),
        .wdata    (wdata),
        .level_q  (level_q),
        .req      (sys_reset_req)
    );

    sysctl_tick #(.CW(TICK_W)) u_tick (
        .clk     (clk),
        .rst_n   (warm_n),
        .tick_en (tick_en),
        .count   (tick_q)
    );

    // Read mux; unmapped words read zero.
    always_comb begin
        case (widx)
            W_IDENT:  rdata = ID_VALUE;
            W_LEDS:   rdata = led_q;
            W_KEY:    rdata = {16'h0000, key_q};
            W_FSET:   rdata = flags_q;
            W_NVSET:  rdata = nvflags_q;
            W_RSTCTL: rdata = level_q;
            W_TICK:   rdata = DW'(tick_q);
            default:  rdata = '0;
        endcase
    end

    // R2: LED word holds when not addressed.
    p_led_hold_r2: assert property (@(posedge clk) disable iff (!warm_n)
        !(wr_en && widx == W_LEDS) |=> $stable(led_q));

    // R11: no reset request in the first cycle after any reset.
    p_req_quiet_r11: assert property (@(posedge clk)
        !warm_n |=> !sys_reset_req);

endmodule

// File: tb/tb_sysctl_regbank.sv
// Scoreboard bench: driver tasks push expected read results, a monitor pops
// and compares them against two copies (variant A and variant C).
module tb_sysctl_regbank;
    import sysctl_pkg::*;

    localparam logic [31:0] IDV = 32'h0A5C_0001;

    typedef struct {
        logic [31:0] exp_a;
        logic [31:0] exp_c;
        logic        req_a;
        logic        req_c;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        mon_req = 1'b0;
    logic [31:0] rdata_a, rdata_c;
    logic        req_a, req_c;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #5 clk = ~clk;

    sysctl_regbank #(.VARIANT(VAR_A), .ID_VALUE(IDV)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
        .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata_a), .sys_reset_req(req_a));

    sysctl_regbank #(.VARIANT(VAR_C), .ID_VALUE(IDV)) dut_c (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
        .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata_c), .sys_reset_req(req_c));

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; mon_req = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] ea,
                      input logic [31:0] ec, input logic ra, input logic rc,
                      input string tag);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = 1'b0; mon_req = 1'b1;
        it.exp_a = ea; it.exp_c = ec; it.req_a = ra; it.req_c = rc; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic rd2(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd(a, e, e, 1'b0, 1'b0, tag);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        wr_en = 1'b0; mon_req = 1'b0; tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic warm_reset();
        @(negedge clk);
        wr_en = 1'b0; mon_req = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cold_reset();
        @(negedge clk);
        wr_en = 1'b0; mon_req = 1'b0; por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
    endtask

    // Monitor: compares one scoreboard item per requested read cycle.
    always @(negedge clk) begin
        #3;
        if (mon_req) begin
            item_t it;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                it = sb_q.pop_front();
                n_cmp++;
                if (rdata_a !== it.exp_a || rdata_c !== it.exp_c ||
                    req_a !== it.req_a || req_c !== it.req_c) begin
                    n_bad++;
                    $display("FAIL %s: rdata A/C %h/%h req A/C %b/%b, expected %h/%h req %b/%b",
                             it.tag, rdata_a, rdata_c, req_a, req_c,
                             it.exp_a, it.exp_c, it.req_a, it.req_c);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R11 reset state, R1 identity
        rd2(12'h000, IDV,  "R1 identity");
        rd2(12'h008, 0,    "R11 led reset");
        rd2(12'h020, 0,    "R11 key reset");
        rd2(12'h030, 0,    "R11 flags reset");
        rd2(12'h038, 0,    "R11 nvflags reset");
        rd2(12'h040, 0,    "R11 rstctl reset");
        rd2(12'h05C, 0,    "R11 tick reset");
        wr(12'h000, 32'hFFFF_FFFF);
        rd2(12'h000, IDV,  "R1 identity write ignored");

        // R2 LED, R10 low address bits ignored
        wr(12'h008, 32'hDEAD_BEEF);
        rd2(12'h008, 32'hDEAD_BEEF, "R2 led write");
        wr(12'h00B, 32'h1234_5678);
        rd2(12'h009, 32'h1234_5678, "R10 low addr bits");

        // R4 flags set/clear
        wr(12'h030, 32'h0000_00F0);
        wr(12'h030, 32'h0000_0F00);
        rd2(12'h030, 32'h0000_0FF0, "R4 flags set accumulates");
        wr(12'h034, 32'h0000_0330);
        rd2(12'h030, 32'h0000_0CC0, "R4 flags clear");
        rd2(12'h034, 0, "R10 clear word reads zero");

        // R5 non-volatile flags
        wr(12'h038, 32'hA000_0005);
        wr(12'h03C, 32'h0000_0004);
        rd2(12'h038, 32'hA000_0001, "R5 nvflags set/clear");
        rd2(12'h03C, 0, "R10 nv clear word reads zero");

        // R6 locked write ignored
        wr(12'h040, 32'h0000_0100);
        rd2(12'h000, IDV, "R6 locked write no request");
        rd2(12'h040, 0,   "R6 locked write no level");

        // R3 key register
        wr(12'h020, 32'h0001_2345);
        rd2(12'h020, 32'h0000_2345, "R3 low 15 bits kept");
        wr(12'h020, 32'h0000_FFFF);
        rd2(12'h020, 32'h0000_7FFF, "R3 bit15 forced low");
        wr(12'h020, 32'h0001_A05F);
        rd2(12'h020, 32'h0000_205F, "R3 near-miss key");
        wr(12'h020, 32'h0000_A05F);
        rd2(12'h020, 32'h0000_A05F, "R3 exact key");

        // R7 / R8 unlocked writes
        wr(12'h040, 32'h0000_0004);
        rd(12'h040, 32'h4, 0, 1'b0, 1'b0, "R7 bit2 no trigger in A, R8 C reads zero");
        wr(12'h040, 32'h0000_0104);
        rd(12'h000, IDV, IDV, 1'b1, 1'b0, "R7 bit8 request, R8 none in C");
        rd(12'h000, IDV, IDV, 1'b0, 1'b0, "R7 request one cycle");
        rd(12'h040, 32'h104, 0, 1'b0, 1'b0, "R6 level stored, R8 C zero");

        // R6 relock
        wr(12'h020, 32'h0000_0000);
        rd2(12'h020, 0, "R3 relock");
        wr(12'h040, 32'h0000_0001);
        rd(12'h040, 32'h104, 0, 1'b0, 1'b0, "R6 relocked write ignored");

        // R10 unmapped space
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        rd2(12'h100, 0, "R10 unmapped reads zero");
        rd2(12'hFFC, 0, "R10 top of window zero");
        rd2(12'h008, 32'h1234_5678, "R10 unmapped write no effect on led");
        rd2(12'h030, 32'h0000_0CC0, "R10 unmapped write no effect on flags");

        // R9 timebase
        ticks(10);
        rd2(12'h05C, 10, "R9 ten ticks");
        for (int i = 0; i < 4; i++) ticks(1);
        rd2(12'h05C, 14, "R9 gapped ticks");

        // R5 warm reset keeps nv flags; others clear
        warm_reset();
        rd2(12'h038, 32'hA000_0001, "R5 nvflags survive warm reset");
        rd2(12'h030, 0, "R4 flags cleared by warm reset");
        rd2(12'h008, 0, "R2 led cleared by warm reset");
        rd2(12'h020, 0, "R11 key cleared");
        rd2(12'h040, 0, "R11 level cleared");
        rd2(12'h05C, 0, "R9 tick cleared by warm reset");
        rd2(12'h000, IDV, "R1 identity after reset");

        cold_reset();
        rd2(12'h038, 0, "R5 nvflags cleared by power-on reset");

        @(negedge clk);
        mon_req = 1'b0;
        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule